// File: doc/BRIEF.md
# Configuration File Header Parser

This block reads the start of a device configuration file one byte at a time over a valid/ready input. It first checks a fixed 13-byte preamble. After the preamble the file is a run of tagged sections, and the block walks them to find the section whose tag letter was requested. When it finds that section it reports the section's length. It then forwards exactly that many payload bytes to a downstream valid/ready port.

A load controller pulses `start` with the wanted tag letter on `req_tag`. It feeds the file bytes and waits for the one-cycle `done` pulse. That pulse carries a found flag, a result code and the 32-bit length. A run can end early in four ways, each with its own code: the preamble does not match, a tag is malformed, a length is implausible, or the byte budget for the search runs out. Every early ending stops the parser in idle.

Top module: `cfg_hdr_parser`

## Requirements
- R1: While reset is held, and after it until a `start` pulse, `in_ready`, `out_valid`, `done` and `found` stay low. Reset is synchronous and active high.
- R2: The first 13 bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first byte that differs is accepted and then ends the run with `done`, `found`=0 and `status`=1. After that no further byte is accepted.
- R3: After the preamble, each section is a tag byte, then a big-endian length, then that many content bytes. Content of a section whose tag differs from the requested one is accepted and dropped, and none of it appears on the output port.
- R4: Tag 0x65 ('e') carries a 4-byte length field. Every other tag carries a 2-byte length field.
- R5: A tag byte outside 0x61..0x65 ('a'..'e') ends the run with `found`=0 and `status`=2.
- R6: A length above 255 under any tag other than 0x65 ends the run with `found`=0 and `status`=3. This check is made before the tag is compared with the requested one. A length of exactly 255 is accepted.
- R7: At most BUDGET bytes (default 100) are accepted after the preamble, counting tag, length and content bytes. When the budget is used up without a match, the run ends with `found`=0 and `status`=4.
- R8: When the length field of the requested tag is complete and passes the R6 check, `done` pulses with `found`=1, `status`=0 and `sec_len` equal to that length.
- R9: After a match, exactly `sec_len` payload bytes are forwarded unchanged from `in_data` to `out_data`, with `in_ready` following `out_ready`. The parser then returns to idle. A zero length goes straight to idle.
- R10: `req_tag` is sampled only on a `start` pulse taken in idle. A `start` pulse while a run is in progress has no effect.
- R11: `done` is a single-cycle pulse, and each run produces exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run and sample `req_tag` (taken only in idle) |
| req_tag | input | 8 | Tag letter of the wanted section |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser takes the input byte this cycle |
| out_valid | output | 1 | Payload byte present downstream |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream takes the payload byte |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Requested section located (valid with `done`) |
| status | output | 3 | Result: 0 found, 1 preamble, 2 bad tag, 3 bad length, 4 budget spent |
| sec_len | output | 32 | Length of the located section |

## Verification
The bench builds the parser with its default parameters: a budget of 100 bytes and a short-length limit of 255. At these values a run of one 90-byte section and one 20-byte section exhausts the budget exactly on a content byte, so the budget stop is reached within a few hundred cycles. A requested section of length 255 sits right on the length limit. Four-byte 'e' lengths are exercised both as the match and as a skipped section, and the output is stalled during forwarding.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int PRE_LEN = 13;
    localparam int PRE_W   = $clog2(PRE_LEN);
    localparam int LEN_W   = 32;
    localparam logic [7:0] TAG_LO   = 8'h61;
    localparam logic [7:0] TAG_HI   = 8'h65;
    localparam logic [7:0] TAG_WIDE = 8'h65;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_TAG,
        PH_LEN,
        PH_SKIP,
        PH_PASS
    } phase_t;

    typedef enum logic [2:0] {
        RES_FOUND  = 3'd0,
        RES_HDR    = 3'd1,
        RES_TAG    = 3'd2,
        RES_LEN    = 3'd3,
        RES_BUDGET = 3'd4
    } result_t;

    function automatic logic [7:0] pre_byte(input logic [PRE_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0, 4'd10, 4'd11: b = 8'h00;
            4'd1:               b = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8: b = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9: b = 8'hF0;
            4'd12:              b = 8'h01;
            default:            b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic tag_legal(input logic [7:0] t);
        return (t >= TAG_LO) && (t <= TAG_HI);
    endfunction

    function automatic logic [2:0] len_bytes(input logic [7:0] t);
        return (t == TAG_WIDE) ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/cfgp_preamble.sv
module cfgp_preamble
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       step,
    input  logic [7:0] data,
    output logic       mismatch,
    output logic       last
);
    logic [PRE_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (step && !last) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign mismatch = (data != pre_byte(idx_q));
    assign last     = (idx_q == PRE_W'(PRE_LEN - 1));
endmodule

// File: rtl/cfgp_len_accum.sv
module cfgp_len_accum
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [7:0]       tag,
    input  logic             step,
    input  logic [7:0]       data,
    output logic [LEN_W-1:0] value_next,
    output logic             last_byte
);
    logic [LEN_W-1:0] value_q;
    logic [2:0]       left_q;

    assign value_next = {value_q[LEN_W-9:0], data};
    assign last_byte  = (left_q == 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            value_q <= '0;
            left_q  <= len_bytes(tag);
        end else if (step) begin
            value_q <= value_next;
            left_q  <= left_q - 3'd1;
        end
    end
endmodule

// File: rtl/cfgp_countdown.sv
module cfgp_countdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign at_one = (rem_q == W'(1));
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import cfgp_pkg::*;
#(
    parameter int BUDGET    = 100,
    parameter int SHORT_MAX = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       req_tag,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             done,
    output logic             found,
    output logic [2:0]       status,
    output logic [LEN_W-1:0] sec_len
);
    localparam int USED_W = $clog2(BUDGET + 1);

    phase_t            phase_q, phase_d;
    logic [7:0]        req_q;
    logic [7:0]        tag_q;
    logic [USED_W-1:0] used_q;
    logic              spent;
    logic              acc;
    logic              begin_run;

    logic              pre_mis, pre_last;
    logic [LEN_W-1:0]  len_next;
    logic              len_last;
    logic              rem_one;
    logic              rem_load;

    logic              fin;
    result_t           fin_code;
    logic              hit;
    logic              bad_len;

    assign spent     = (used_q == USED_W'(BUDGET));
    assign begin_run = (phase_q == PH_IDLE) && start;
    assign acc       = in_valid && in_ready;
    assign bad_len   = (tag_q != TAG_WIDE) && (len_next > LEN_W'(SHORT_MAX));

    always_comb begin
        case (phase_q)
            PH_PRE:                   in_ready = 1'b1;
            PH_TAG, PH_LEN, PH_SKIP:  in_ready = !spent;
            PH_PASS:                  in_ready = out_ready;
            default:                  in_ready = 1'b0;
        endcase
    end

    assign out_valid = (phase_q == PH_PASS) && in_valid;
    assign out_data  = in_data;

    cfgp_preamble u_pre (
        .clk      (clk),
        .rst      (rst),
        .clear    (begin_run),
        .step     (acc && (phase_q == PH_PRE)),
        .data     (in_data),
        .mismatch (pre_mis),
        .last     (pre_last)
    );

    cfgp_len_accum u_len (
        .clk        (clk),
        .rst        (rst),
        .load       (acc && (phase_q == PH_TAG)),
        .tag        (in_data),
        .step       (acc && (phase_q == PH_LEN)),
        .data       (in_data),
        .value_next (len_next),
        .last_byte  (len_last)
    );

    cfgp_countdown #(.W(LEN_W)) u_rem (
        .clk      (clk),
        .rst      (rst),
        .load     (rem_load),
        .load_val (len_next),
        .dec      (acc && ((phase_q == PH_SKIP) || (phase_q == PH_PASS))),
        .at_one   (rem_one)
    );

    always_comb begin
        phase_d  = phase_q;
        fin      = 1'b0;
        fin_code = RES_FOUND;
        hit      = 1'b0;
        rem_load = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start) phase_d = PH_PRE;
            end
            PH_PRE: begin
                if (acc) begin
                    if (pre_mis) begin
                        fin      = 1'b1;
                        fin_code = RES_HDR;
                    end else if (pre_last) begin
                        phase_d = PH_TAG;
                    end
                end
            end
            PH_TAG: begin
                if (spent) begin
                    fin      = 1'b1;
                    fin_code = RES_BUDGET;
                end else if (acc) begin
                    if (!tag_legal(in_data)) begin
                        fin      = 1'b1;
                        fin_code = RES_TAG;
                    end else begin
                        phase_d = PH_LEN;
                    end
                end
            end
            PH_LEN: begin
                if (spent) begin
                    fin      = 1'b1;
                    fin_code = RES_BUDGET;
                end else if (acc && len_last) begin
                    if (bad_len) begin
                        fin      = 1'b1;
                        fin_code = RES_LEN;
                    end else if (tag_q == req_q) begin
                        hit      = 1'b1;
                        rem_load = 1'b1;
                        phase_d  = (len_next == '0) ? PH_IDLE : PH_PASS;
                    end else begin
                        rem_load = 1'b1;
                        phase_d  = (len_next == '0) ? PH_TAG : PH_SKIP;
                    end
                end
            end
            PH_SKIP: begin
                if (spent) begin
                    fin      = 1'b1;
                    fin_code = RES_BUDGET;
                end else if (acc && rem_one) begin
                    phase_d = PH_TAG;
                end
            end
            PH_PASS: begin
                if (acc && rem_one) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
        if (fin) phase_d = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            req_q   <= '0;
            tag_q   <= '0;
            used_q  <= '0;
            done    <= 1'b0;
            found   <= 1'b0;
            status  <= 3'd0;
            sec_len <= '0;
        end else begin
            phase_q <= phase_d;
            done    <= fin || hit;
            found   <= hit;
            if (begin_run) begin
                req_q   <= req_tag;
                used_q  <= '0;
                sec_len <= '0;
            end
            if (acc && (phase_q == PH_TAG)) tag_q <= in_data;
            if (acc && ((phase_q == PH_TAG) || (phase_q == PH_LEN) || (phase_q == PH_SKIP)))
                used_q <= used_q + 1'b1;
            if (fin) status <= fin_code;
            if (hit) begin
                status  <= RES_FOUND;
                sec_len <= len_next;
            end
        end
    end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int BUDGET = 100,
    parameter int USED_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              done,
    input logic              found,
    input logic [31:0]       sec_len,
    input logic [7:0]        tag_seen,
    input logic [USED_W-1:0] used
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!done && !found && !in_ready && !out_valid)); // R1

    AST_ERROR_HALTS: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |=> !in_ready); // R2

    AST_SHORT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (done && found && (sec_len > 32'd255)) |-> (tag_seen == 8'h65)); // R6

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
        used <= USED_W'(BUDGET)); // R7

    AST_FOUND_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        found |-> done); // R8

    AST_FWD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
endmodule

bind cfg_hdr_parser cfgp_checker #(
    .BUDGET (BUDGET),
    .USED_W (USED_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .done      (done),
    .found     (found),
    .sec_len   (sec_len),
    .tag_seen  (tag_q),
    .used      (used_q)
);

// File: tb/sim_cfg_hdr_parser.sv
module sim_cfg_hdr_parser;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  req_tag = 8'h00;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        done;
    logic        found;
    logic [2:0]  status;
    logic [31:0] sec_len;

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    int out_cnt = 0;
    logic        got_found;
    logic [2:0]  got_status;
    logic [31:0] got_len;
    logic [7:0]  out_buf [0:63];
    logic [7:0]  q [$];
    bit          ended = 0;

    always #(CLK_P/2) clk = ~clk;

    cfg_hdr_parser u0 (
        .clk(clk), .rst(rst), .start(start), .req_tag(req_tag),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .done(done), .found(found), .status(status), .sec_len(sec_len)
    );

    always @(negedge clk) begin
        if (done) begin
            n_done++;
            got_found  = found;
            got_status = status;
            got_len    = sec_len;
        end
        if (out_valid && out_ready) begin
            if (out_cnt < 64) out_buf[out_cnt] = out_data;
            out_cnt++;
        end
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        step();
        rst = 1'b0;
        step();
    endtask

    task automatic go(input logic [7:0] t);
        @(negedge clk);
        n_done = 0;
        out_cnt = 0;
        got_found = 1'b0;
        got_status = 3'd7;
        got_len = '0;
        step();
        start = 1'b1;
        req_tag = t;
        step();
        start = 1'b0;
        req_tag = 8'h00;
        q.delete();
    endtask

    task automatic push(input logic [7:0] b, output bit ok);
        in_data = b;
        in_valid = 1'b1;
        ok = 0;
        for (int i = 0; i < 20 && !ok; i++) begin
            @(negedge clk);
            if (in_ready) ok = 1;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic send(output int accepted);
        bit ok;
        accepted = 0;
        foreach (q[i]) begin
            push(q[i], ok);
            if (!ok) break;
            accepted++;
        end
        repeat (3) step();
    endtask

    task automatic add_pre();
        logic [7:0] p [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                               8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
        foreach (p[i]) q.push_back(p[i]);
    endtask

    task automatic add_sec(input logic [7:0] t, input logic [31:0] len, input int fill, input logic [7:0] base);
        q.push_back(t);
        if (t == 8'h65) begin
            q.push_back(len[31:24]);
            q.push_back(len[23:16]);
        end
        q.push_back(len[15:8]);
        q.push_back(len[7:0]);
        for (int i = 0; i < fill; i++) q.push_back(base + 8'(i));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        step();
        step();
        @(negedge clk);
        chk("R1 in_ready in reset", in_ready, 0);
        chk("R1 done in reset", done, 0);
        step();
        rst = 1'b0;
        repeat (3) step();
        @(negedge clk);
        chk("R1 in_ready idle", in_ready, 0);
        chk("R1 out_valid idle", out_valid, 0);
        chk("R1 found idle", found, 0);
        step();
        in_valid = 1'b0;
    endtask

    task automatic t_header();
        int acc;
        do_reset();
        go(8'h61);
        add_pre();
        q[3] = 8'hF1;
        send(acc);
        chk("R2 bytes taken", acc, 4);
        chk("R2 status", got_status, 1);
        chk("R2 found", got_found, 0);
        chk("R11 one done", n_done, 1);
        @(negedge clk);
        chk("R2 halted", in_ready, 0);
    endtask

    task automatic t_walk();
        int acc;
        bit mism;
        do_reset();
        go(8'h63);
        add_pre();
        add_sec(8'h61, 3, 3, 8'hA0);
        add_sec(8'h62, 2, 2, 8'hB0);
        add_sec(8'h63, 5, 5, 8'h10);
        q.push_back(8'h77);
        send(acc);
        chk("R3 bytes taken", acc, q.size() - 1);
        chk("R8 found", got_found, 1);
        chk("R8 status", got_status, 0);
        chk("R8 length", got_len, 5);
        chk("R3 R9 forwarded count", out_cnt, 5);
        mism = 0;
        for (int i = 0; i < 5; i++) if (out_buf[i] != 8'h10 + 8'(i)) mism = 1;
        chk("R9 payload bytes", mism, 0);
        chk("R11 one done", n_done, 1);
        @(negedge clk);
        chk("R9 idle after payload", in_ready, 0);
    endtask

    task automatic t_wide();
        int acc;
        do_reset();
        go(8'h65);
        add_pre();
        add_sec(8'h62, 1, 1, 8'h30);
        add_sec(8'h65, 32'h0001_2345, 0, 8'h00);
        send(acc);
        chk("R4 wide length match", got_len, 32'h0001_2345);
        chk("R4 wide found", got_found, 1);
        do_reset();
        go(8'h64);
        add_pre();
        add_sec(8'h65, 3, 3, 8'h40);
        add_sec(8'h64, 2, 2, 8'h50);
        send(acc);
        chk("R4 skip wide section", got_len, 2);
        chk("R4 skip wide found", got_found, 1);
        chk("R4 skip wide forwarded", out_cnt, 2);
    endtask

    task automatic t_bad_tag();
        int acc;
        do_reset();
        go(8'h61);
        add_pre();
        add_sec(8'h66, 1, 1, 8'h00);
        send(acc);
        chk("R5 status", got_status, 2);
        chk("R5 found", got_found, 0);
        chk("R5 bytes taken", acc, 14);
    endtask

    task automatic t_bad_len();
        int acc;
        do_reset();
        go(8'h61);
        add_pre();
        add_sec(8'h62, 32'h100, 0, 8'h00);
        send(acc);
        chk("R6 long skipped section", got_status, 3);
        do_reset();
        go(8'h61);
        add_pre();
        add_sec(8'h61, 32'h100, 0, 8'h00);
        send(acc);
        chk("R6 long requested section", got_status, 3);
        chk("R6 long not found", got_found, 0);
        do_reset();
        go(8'h61);
        add_pre();
        add_sec(8'h61, 32'hFF, 0, 8'h00);
        send(acc);
        chk("R6 length 255 found", got_found, 1);
        chk("R6 length 255 value", got_len, 255);
    endtask

    task automatic t_budget();
        int acc;
        do_reset();
        go(8'h63);
        add_pre();
        add_sec(8'h61, 90, 90, 8'h00);
        add_sec(8'h62, 20, 20, 8'h00);
        add_sec(8'h63, 1, 1, 8'h00);
        send(acc);
        chk("R7 bytes after preamble", acc - 13, 100);
        chk("R7 status", got_status, 4);
        chk("R7 found", got_found, 0);
        chk("R7 nothing forwarded", out_cnt, 0);
    endtask

    task automatic t_zero();
        int acc;
        do_reset();
        go(8'h62);
        add_pre();
        add_sec(8'h62, 0, 0, 8'h00);
        q.push_back(8'h99);
        send(acc);
        chk("R9 zero length found", got_found, 1);
        chk("R9 zero length value", got_len, 0);
        chk("R9 zero length no output", out_cnt, 0);
        chk("R9 zero length idle", acc, q.size() - 1);
    endtask

    task automatic t_stall();
        int acc;
        bit ok;
        do_reset();
        go(8'h61);
        add_pre();
        add_sec(8'h61, 3, 0, 8'h00);
        send(acc);
        out_ready = 1'b0;
        push(8'hC0, ok);
        chk("R9 stalled byte held", ok, 0);
        chk("R9 stalled no output", out_cnt, 0);
        out_ready = 1'b1;
        push(8'hC0, ok);
        push(8'hC1, ok);
        push(8'hC2, ok);
        repeat (2) step();
        chk("R9 after stall count", out_cnt, 3);
        chk("R9 after stall last", out_buf[2], 8'hC2);
    endtask

    task automatic t_restart();
        bit ok;
        int acc;
        do_reset();
        go(8'h62);
        add_pre();
        for (int i = 0; i < 5; i++) push(q[i], ok);
        start = 1'b1;
        req_tag = 8'h61;
        step();
        start = 1'b0;
        req_tag = 8'h00;
        q = q[5:$];
        add_sec(8'h61, 1, 1, 8'h20);
        add_sec(8'h62, 2, 2, 8'h21);
        send(acc);
        chk("R10 original tag kept", got_len, 2);
        chk("R10 found", got_found, 1);
        chk("R10 one done", n_done, 1);
    endtask

    initial begin
        t_reset();
        t_header();
        t_walk();
        t_wide();
        t_bad_tag();
        t_bad_len();
        t_budget();
        t_zero();
        t_stall();
        t_restart();
        summary();
    end
endmodule